// File: doc/BRIEF.md
# Vectored Interrupt Controller with NMI

This block gathers 32 level-sensitive interrupt lines and presents them to a processor core in two ways. Most lines feed a pending vector. That vector is gated by a software-programmed mask and then encoded into an 8-bit interrupt vector with a request wire. When exactly one masked source is pending, the vector names that source. When several are pending, a fixed shared vector is issued and the choice of which to service first is left to software. The two highest lines skip masking and vector encoding completely and drive a separate non-maskable interrupt wire.

Software reaches the block through a plain 32-bit register port. The port has one-cycle read latency and exposes four registers: the mask, the raw pending vector, the masked pending vector and the NMI status. The request, vector and NMI outputs are registered and follow the inputs and mask writes after one clock. The register port and the interrupt outputs carry no data stream, so they have no valid/ready handshake and no back-pressure. A read or write is accepted in every cycle in which it is strobed.

Top module: `vic_top`

## Requirements
- R1: While reset is asserted (rst_n low), the mask, raw pending and NMI status registers hold zero. `irq_vec` is 0, `irq_req` and `nmi_req` are low, and `rdata` is 0.
- R2: The word selected is the byte address divided by 4, so the two low address bits are ignored. The words are: 0 mask (read/write), 1 raw pending, 2 masked pending, 3 NMI status, 4 reserved. Word 4 and any higher word read as 0. When `rd_en` is high at a clock edge, `rdata` shows the addressed word from that edge on. Otherwise `rdata` keeps its last value.
- R3: The masked pending word always equals raw pending AND mask.
- R4: If exactly one masked pending bit i is set, `irq_vec` is 0x31 + i.
- R5: If two or more masked pending bits are set, `irq_vec` is 0x30.
- R6: If no masked bit is pending, `irq_vec` is 0 and `irq_req` is low. `irq_req` is high exactly when `irq_vec` is nonzero.
- R7: Each input line n with 1 ≤ n ≤ 29 sets raw pending bit n−1 while it is high and clears that bit while it is low. Line 0 has no effect on any register or output. Raw pending bits 29 to 31 stay 0.
- R8: Lines 30 and 31 set NMI status bits 30 and 31 while high and clear them while low. They never appear in raw pending and never affect `irq_vec`. `nmi_req` is the OR of all NMI status bits.
- R9: Only word 0 can be written. A write to any other word changes no register.
- R10: `irq_vec`, `irq_req` and `nmi_req` take their new values at the first clock edge after a line change or a mask write.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the strobe |
| irq_req | output | 1 | Maskable interrupt request |
| irq_vec | output | 8 | Interrupt vector |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The tracking assertions assume that the interrupt lines are synchronous to `clk` and stable around each edge. They also assume that a single strobe carries one access, so each cycle is a read, a write or neither. The stimulus changes lines and strobes only on the falling edge and issues one access per step. It does not change the lines in a step that reads a pending register, so each expected read value is defined by the state before that edge.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Word selectors of the register port (byte address / 4).
  typedef enum logic [2:0] {
    WSEL_MASK   = 3'd0,
    WSEL_RAW    = 3'd1,
    WSEL_MASKED = 3'd2,
    WSEL_NMI    = 3'd3,
    WSEL_RSVD   = 3'd4
  } vic_word_e;

  localparam int unsigned VIC_WORD_W = 3;

endpackage

// File: rtl/vic_line_capture.sv
module vic_line_capture #(
  parameter int unsigned N_LINES   = 32,
  parameter int unsigned NMI_LINES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  output logic [N_LINES-1:0] raw_next,
  output logic [N_LINES-1:0] raw_q,
  output logic [N_LINES-1:0] nmi_q
);

  // Lines 1..NORM_TOP feed raw bits 0..NORM_TOP-1; the top NMI_LINES go to NMI status.
  localparam int unsigned NMI_BASE = N_LINES - NMI_LINES;
  localparam int unsigned NORM_TOP = NMI_BASE - 1;

  function automatic logic [N_LINES-1:0] low_ones(input int unsigned n);
    logic [N_LINES-1:0] r;
    for (int i = 0; i < N_LINES; i++) r[i] = (i < n);
    return r;
  endfunction

  localparam logic [N_LINES-1:0] NORM_KEEP = low_ones(NORM_TOP);
  localparam logic [N_LINES-1:0] NMI_KEEP  = ~low_ones(NMI_BASE);

  logic [N_LINES-1:0] nmi_next;

  // Line 0 is shifted out and has no pending bit.
  assign raw_next = (lines >> 1) & NORM_KEEP;
  assign nmi_next = lines & NMI_KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      nmi_q <= '0;
    end else begin
      raw_q <= raw_next;
      nmi_q <= nmi_next;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar g = 1; g <= NORM_TOP; g++) begin : g_raw_chk
    AST_RAW_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (raw_q[g-1] == $past(lines[g]))) else $error("raw bit"); // R7
  end

  for (genvar g = NMI_BASE; g < N_LINES; g++) begin : g_nmi_chk
    AST_NMI_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (nmi_q[g] == $past(lines[g]))) else $error("nmi bit"); // R8
  end

  AST_RAW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~NORM_KEEP) == '0) else $error("raw top"); // R7

endmodule

// File: rtl/vic_vec_encode.sv
module vic_vec_encode #(
  parameter int unsigned         W          = 32,
  parameter int unsigned         VEC_W      = 8,
  parameter logic [VEC_W-1:0]    BASE_VEC   = 8'h31,
  parameter logic [VEC_W-1:0]    SHARED_VEC = 8'h30
) (
  input  logic [W-1:0]     pend,
  output logic [VEC_W-1:0] vec_c,
  output logic             any_c
);

  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

  function automatic logic [W-1:0] bit_sel(input int unsigned b);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ((i >> b) & 1) == 1;
    return r;
  endfunction

  logic [IDX_W-1:0] idx;
  logic             multi;

  // Index of the set bit, valid when exactly one bit is set.
  for (genvar b = 0; b < IDX_W; b++) begin : g_idx
    localparam logic [W-1:0] SEL = bit_sel(b);
    assign idx[b] = |(pend & SEL);
  end

  assign any_c = |pend;
  assign multi = |(pend & (pend - W'(1)));

  always_comb begin
    if (!any_c)     vec_c = '0;
    else if (multi) vec_c = SHARED_VEC;
    else            vec_c = BASE_VEC + VEC_W'(idx);
  end

endmodule

// File: rtl/vic_reg_port.sv
module vic_reg_port
  import vic_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_q,
  input  logic [DATA_W-1:0] masked_q,
  input  logic [DATA_W-1:0] nmi_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_next,
  output logic [DATA_W-1:0] rdata
);

  logic [VIC_WORD_W-1:0] word;
  logic                  hit_mask;
  logic [DATA_W-1:0]     rd_mux;

  assign word      = VIC_WORD_W'(addr >> 2);
  assign hit_mask  = wr_en && (vic_word_e'(word) == WSEL_MASK);
  assign mask_next = hit_mask ? wdata : mask_q;

  always_comb begin
    case (vic_word_e'(word))
      WSEL_MASK:   rd_mux = mask_q;
      WSEL_RAW:    rd_mux = raw_q;
      WSEL_MASKED: rd_mux = masked_q;
      WSEL_NMI:    rd_mux = nmi_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      rdata  <= '0;
    end else begin
      mask_q <= mask_next;
      if (rd_en) rdata <= rd_mux;
    end
  end

  AST_MASK_ONLY_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (word == VIC_WORD_W'(0))) |=> $stable(mask_q)) else $error("mask"); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)) else $error("rdata"); // R2

endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int unsigned      N_LINES    = 32,
  parameter int unsigned      NMI_LINES  = 2,
  parameter int unsigned      ADDR_W     = 5,
  parameter int unsigned      VEC_W      = 8,
  parameter logic [VEC_W-1:0] BASE_VEC   = 8'h31,
  parameter logic [VEC_W-1:0] SHARED_VEC = 8'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] rdata,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               nmi_req
);

  logic [N_LINES-1:0] raw_next, raw_q, nmi_q;
  logic [N_LINES-1:0] mask_q, mask_next;
  logic [N_LINES-1:0] masked_q, masked_next;
  logic [VEC_W-1:0]   vec_c;
  logic               any_c;

  vic_line_capture #(
    .N_LINES   (N_LINES),
    .NMI_LINES (NMI_LINES)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .raw_next (raw_next),
    .raw_q    (raw_q),
    .nmi_q    (nmi_q)
  );

  vic_reg_port #(
    .DATA_W (N_LINES),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .raw_q     (raw_q),
    .masked_q  (masked_q),
    .nmi_q     (nmi_q),
    .mask_q    (mask_q),
    .mask_next (mask_next),
    .rdata     (rdata)
  );

  assign masked_q    = raw_q & mask_q;
  // Encode the state the registers take at this edge so outputs move with them.
  assign masked_next = raw_next & mask_next;

  vic_vec_encode #(
    .W          (N_LINES),
    .VEC_W      (VEC_W),
    .BASE_VEC   (BASE_VEC),
    .SHARED_VEC (SHARED_VEC)
  ) u_enc (
    .pend  (masked_next),
    .vec_c (vec_c),
    .any_c (any_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_vec <= '0;
      irq_req <= 1'b0;
    end else begin
      irq_vec <= vec_c;
      irq_req <= any_c;
    end
  end

  assign nmi_req = |nmi_q;

  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec > SHARED_VEC) |-> ($countones(masked_q) == 1)) else $error("single"); // R4

  AST_SHARED_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec == SHARED_VEC) |-> ($countones(masked_q) > 1)) else $error("shared"); // R5

  AST_REQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_vec != '0)) else $error("req"); // R6

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_q == '0) |-> !irq_req) else $error("idle"); // R6

endmodule

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        rd;
    logic [31:0] rd_exp;
    logic [7:0]  vec;
    logic        req;
    logic        nmi;
    logic [63:0] tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        nmi_req;

  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t sb_q[$];

  logic [31:0] m_mask = '0;
  logic [31:0] m_lines = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .nmi_req   (nmi_req)
  );

  function automatic logic [31:0] raw_of(input logic [31:0] l);
    logic [31:0] r = '0;
    for (int n = 1; n <= 29; n++) r[n-1] = l[n];
    return r;
  endfunction

  function automatic logic [31:0] nmi_of(input logic [31:0] l);
    return {l[31:30], 30'd0};
  endfunction

  function automatic logic [7:0] vec_of(input logic [31:0] m);
    int cnt = 0;
    int pos = 0;
    for (int i = 0; i < 32; i++) if (m[i]) begin cnt++; pos = i; end
    if (cnt == 0) return 8'h00;
    if (cnt > 1)  return 8'h30;
    return 8'h31 + 8'(pos);
  endfunction

  function automatic logic [31:0] word_of(input logic [4:0] a);
    case (a >> 2)
      0: return m_mask;
      1: return raw_of(m_lines);
      2: return raw_of(m_lines) & m_mask;
      3: return nmi_of(m_lines);
      default: return 32'd0;
    endcase
  endfunction

  // Driver: one access per step; expectations are pushed after the edge.
  task automatic step(input logic [31:0] l, input logic w, input logic r,
                      input logic [4:0] a, input logic [31:0] d, input logic [63:0] tag);
    exp_t e;
    @(negedge clk);
    irq_lines = l; wr_en = w; rd_en = r; addr = a; wdata = d;
    e.rd     = r;
    e.rd_exp = word_of(a);
    if (w && (a >> 2) == 0) m_mask = d;
    m_lines = l;
    e.vec = vec_of(raw_of(m_lines) & m_mask);
    e.req = (e.vec != 8'h00);
    e.nmi = (nmi_of(m_lines) != 0);
    e.tag = tag;
    @(posedge clk);
    sb_q.push_back(e);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (irq_vec !== e.vec || irq_req !== e.req || nmi_req !== e.nmi) begin
        n_bad++;
        $display("FAIL [%0s] vec/req/nmi actual=%h/%b/%b expected=%h/%b/%b",
                 e.tag, irq_vec, irq_req, nmi_req, e.vec, e.req, e.nmi);
      end
      if (e.rd) begin
        n_cmp++;
        if (rdata !== e.rd_exp) begin
          n_bad++;
          $display("FAIL [%0s] rdata actual=%h expected=%h", e.tag, rdata, e.rd_exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL [R10] watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset holds everything at zero even with lines active.
    irq_lines = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (irq_vec !== 8'h00 || irq_req !== 1'b0 || nmi_req !== 1'b0 || rdata !== 32'h0) begin
      n_bad++;
      $display("FAIL [R1] reset actual=%h/%b/%b/%h expected=00/0/0/00000000",
               irq_vec, irq_req, nmi_req, rdata);
    end
    irq_lines = '0;
    rst_n = 1'b1;

    step(32'h0, 1'b0, 1'b1, 5'h00, 32'h0, "R1");           // mask reads 0
    step(32'h0, 1'b1, 1'b0, 5'h00, 32'hFFFF_FFFF, "R6");   // nothing pending
    step(32'h0000_0002, 1'b0, 1'b0, 5'h00, 32'h0, "R4");   // line1 -> 0x31
    step(32'h2000_0000, 1'b0, 1'b0, 5'h00, 32'h0, "R4");   // line29 -> 0x4D
    step(32'h0000_0001, 1'b0, 1'b0, 5'h00, 32'h0, "R7");   // line0 ignored
    step(32'h0000_0001, 1'b0, 1'b1, 5'h04, 32'h0, "R7");   // raw stays 0
    step(32'h0000_0220, 1'b0, 1'b0, 5'h00, 32'h0, "R5");   // two -> 0x30
    step(32'h0000_0220, 1'b1, 1'b0, 5'h00, 32'h10, "R10"); // mask write, same edge
    step(32'h0000_0220, 1'b0, 1'b1, 5'h04, 32'h0, "R2");   // raw 0x110
    step(32'h0000_0220, 1'b0, 1'b1, 5'h08, 32'h0, "R3");   // masked 0x10
    step(32'h0000_0220, 1'b0, 1'b1, 5'h07, 32'h0, "R2");   // low bits ignored
    step(32'h0000_0220, 1'b1, 1'b0, 5'h04, 32'h0, "R9");
    step(32'h0000_0220, 1'b1, 1'b0, 5'h0C, 32'h0, "R9");
    step(32'h0000_0220, 1'b1, 1'b0, 5'h10, 32'hFFFF_FFFF, "R9");
    step(32'h0000_0220, 1'b0, 1'b1, 5'h00, 32'h0, "R9");   // mask still 0x10
    step(32'h0000_0220, 1'b0, 1'b1, 5'h10, 32'h0, "R2");   // reserved 0
    step(32'h0000_0220, 1'b0, 1'b1, 5'h18, 32'h0, "R2");   // beyond map 0
    step(32'h4000_0000, 1'b1, 1'b0, 5'h00, 32'hFFFF_FFFF, "R8");
    step(32'hC000_0000, 1'b0, 1'b0, 5'h00, 32'h0, "R8");
    step(32'hC000_0000, 1'b0, 1'b1, 5'h0C, 32'h0, "R8");
    step(32'hC000_0000, 1'b0, 1'b1, 5'h04, 32'h0, "R8");   // not in raw
    step(32'h8000_0004, 1'b0, 1'b0, 5'h00, 32'h0, "R8");   // nmi + line2
    step(32'h0000_0000, 1'b0, 1'b0, 5'h00, 32'h0, "R10");
    for (int k = 1; k <= 29; k++)
      step(32'h1 << k, 1'b0, 1'b0, 5'h00, 32'h0, "R4");
    for (int k = 1; k < 29; k++)
      step((32'h1 << k) | (32'h1 << (k + 1)), 1'b0, 1'b0, 5'h00, 32'h0, "R5");
    step(32'h3FFF_FFFE, 1'b0, 1'b0, 5'h00, 32'h0, "R5");
    step(32'h3FFF_FFFE, 1'b1, 1'b0, 5'h00, 32'h0000_0100, "R3");
    step(32'h3FFF_FFFE, 1'b0, 1'b1, 5'h08, 32'h0, "R3");
    step(32'h3FFF_FFFE, 1'b1, 1'b0, 5'h00, 32'h0, "R6");   // all masked off
    step(32'h3FFF_FFFE, 1'b0, 1'b1, 5'h08, 32'h0, "R6");
    step(32'h0, 1'b0, 1'b0, 5'h00, 32'h0, "R6");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule